// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a two-bank low-power SDRAM from power-on to a usable state. After reset it holds the clock enable high and sends only NOP commands until a programmable start-up delay has elapsed. It then issues one precharge of all banks and two auto-refresh commands. It loads the ordinary mode register and, after that, the extended mode register. The gap between consecutive commands follows clock-count parameters for the precharge, refresh and register-load recovery times.

The two register words come in as opcode inputs, and the block places them on the address bus. Address bit 11 selects the register: 0 selects the ordinary mode register and 1 selects the extended one. Bits that must be written as zero are forced to zero, whatever the opcode inputs carry. When the sequence is complete the block raises a done flag and keeps the bus idle, so that a normal controller can take over. Asserting reset at any time restarts the whole sequence.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is high the outputs show NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1), `addr` is 0, `init_done` is 0 and `cke` is 1.
- R2: `cke` is 1 in every cycle, during reset and after it.
- R3: After reset is released, only NOPs appear until the precharge command, which appears after the STARTUP_CYCLES-th rising edge that samples `rst` low.
- R4: The precharge is encoded `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, with `addr`=12'h400 (bit 10 high selects all banks).
- R5: Commands come in a fixed order, each spaced from the one before by a set number of cycles, with NOPs in between. The precharge is followed TRP_CYCLES later by an auto-refresh (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, `addr`=0). A second auto-refresh follows TRFC_CYCLES after that. The mode-register load follows TRFC_CYCLES later. The extended-register load follows TMRD_CYCLES after that.
- R6: The mode-register load is encoded with all four command pins low. Its `addr[11]` and `addr[10]` are 0, `addr[8:7]` is 0, and `addr[9]` and `addr[6:0]` copy `mr_op[9]` and `mr_op[6:0]`.
- R7: The extended-register load is also encoded with all four command pins low. Its `addr[11]` is 1, `addr[10:7]` is 0 and `addr[6:0]` copies `emr_op[6:0]`.
- R8: `init_done` rises exactly TMRD_CYCLES cycles after the cycle that shows the extended-register load.
- R9: Once `init_done` is high it stays high, and every later cycle shows NOP until reset.
- R10: Asserting `rst` part-way through the sequence or after it returns the outputs to the R1 state. After release, the full sequence runs again with the R3 and R5 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mr_op | input | 11 | Opcode for the ordinary mode register (A10:A0) |
| emr_op | input | 11 | Opcode for the extended mode register (A10:A0) |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | Address bus; bit 11 is the bank / register select |
| init_done | output | 1 | High once initialization is complete |

## Verification
If the step register went wrong, the port would show a command out of order or a command the scoreboard does not expect. This is seen on the very cycle that command reaches the bus. If the interval counter went wrong, an expected command would appear one or more cycles early or late against its computed cycle index. A wrong value would also shift the rise of `init_done`. The scoreboard compares every non-NOP command against its expected cycle and pin and address values. Forcing reserved address bits to zero is checked with all-ones opcodes, and a reset partway through the sequence must give a clean restart.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

  localparam int ADDR_W  = 12;
  localparam int OP_W    = ADDR_W - 1;
  localparam int AP_BIT  = 10;

  // Bits of each opcode that reach the bus; the rest are forced to zero.
  localparam logic [OP_W-1:0] MODE_KEEP = 11'b010_0111_1111;
  localparam logic [OP_W-1:0] EXT_KEEP  = 11'b000_0111_1111;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_PRE,   ST_PRE_GAP,
    ST_REF_A, ST_REF_A_GAP,
    ST_REF_B, ST_REF_B_GAP,
    ST_MODE,  ST_MODE_GAP,
    ST_EXT,   ST_EXT_GAP,
    ST_DONE
  } step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  localparam pin_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam pin_cmd_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam pin_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam pin_cmd_t CMD_LOAD = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  function automatic step_e step_after(step_e s);
    case (s)
      ST_WAIT:      return ST_PRE;
      ST_PRE:       return ST_PRE_GAP;
      ST_PRE_GAP:   return ST_REF_A;
      ST_REF_A:     return ST_REF_A_GAP;
      ST_REF_A_GAP: return ST_REF_B;
      ST_REF_B:     return ST_REF_B_GAP;
      ST_REF_B_GAP: return ST_MODE;
      ST_MODE:      return ST_MODE_GAP;
      ST_MODE_GAP:  return ST_EXT;
      ST_EXT:       return ST_EXT_GAP;
      default:      return ST_DONE;
    endcase
  endfunction

endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] span_m1,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == span_m1);

  always_ff @(posedge clk) begin
    if (rst || last) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/sdram_pwrup_fsm.sv
module sdram_pwrup_fsm
  import sdram_pwrup_pkg::*;
#(
  parameter int STARTUP_CYCLES = 12500,
  parameter int TRP_CYCLES     = 3,
  parameter int TRFC_CYCLES    = 9,
  parameter int TMRD_CYCLES    = 2,
  parameter int CNT_W          = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             last,
  output step_e            step_d,
  output logic [CNT_W-1:0] span_m1
);

  localparam logic [CNT_W-1:0] SPAN_WAIT = CNT_W'(STARTUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] SPAN_TRP  = CNT_W'(TRP_CYCLES - 2);
  localparam logic [CNT_W-1:0] SPAN_TRFC = CNT_W'(TRFC_CYCLES - 2);
  localparam logic [CNT_W-1:0] SPAN_TMRD = CNT_W'(TMRD_CYCLES - 2);

  step_e step_q;

  always_comb begin
    case (step_q)
      ST_WAIT:                    span_m1 = SPAN_WAIT;
      ST_PRE_GAP:                 span_m1 = SPAN_TRP;
      ST_REF_A_GAP, ST_REF_B_GAP: span_m1 = SPAN_TRFC;
      ST_MODE_GAP, ST_EXT_GAP:    span_m1 = SPAN_TMRD;
      default:                    span_m1 = '0;
    endcase
  end

  assign step_d = (last && step_q != ST_DONE) ? step_after(step_q) : step_q;

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_WAIT;
    else     step_q <= step_d;
  end

endmodule

// File: rtl/sdram_pwrup_drive.sv
module sdram_pwrup_drive
  import sdram_pwrup_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  step_e             step_d,
  input  logic [OP_W-1:0]   mr_op,
  input  logic [OP_W-1:0]   emr_op,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  pin_cmd_t          cmd_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    case (step_d)
      ST_PRE: begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
      end
      ST_REF_A, ST_REF_B: cmd_d = CMD_REF;
      ST_MODE: begin
        cmd_d  = CMD_LOAD;
        addr_d = {1'b0, mr_op & MODE_KEEP};
      end
      ST_EXT: begin
        cmd_d  = CMD_LOAD;
        addr_d = {1'b1, emr_op & EXT_KEEP};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      addr      <= '0;
      init_done <= 1'b0;
      cke       <= 1'b1;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_d;
      addr      <= addr_d;
      init_done <= (step_d == ST_DONE);
      cke       <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_pwrup_pkg::*;
#(
  parameter int STARTUP_CYCLES = 12500,
  parameter int TRP_CYCLES     = 3,
  parameter int TRFC_CYCLES    = 9,
  parameter int TMRD_CYCLES    = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [10:0] mr_op,
  input  logic [10:0] emr_op,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [11:0] addr,
  output logic        init_done
);

  localparam int GAP_MAX = (TRP_CYCLES > TRFC_CYCLES)
                         ? ((TRP_CYCLES > TMRD_CYCLES) ? TRP_CYCLES : TMRD_CYCLES)
                         : ((TRFC_CYCLES > TMRD_CYCLES) ? TRFC_CYCLES : TMRD_CYCLES);
  localparam int LONGEST = (STARTUP_CYCLES > GAP_MAX) ? STARTUP_CYCLES : GAP_MAX;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  step_e            step_d;
  logic [CNT_W-1:0] span_m1;
  logic             last;

  sdram_pwrup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .span_m1 (span_m1),
    .last    (last)
  );

  sdram_pwrup_fsm #(
    .STARTUP_CYCLES (STARTUP_CYCLES),
    .TRP_CYCLES     (TRP_CYCLES),
    .TRFC_CYCLES    (TRFC_CYCLES),
    .TMRD_CYCLES    (TMRD_CYCLES),
    .CNT_W          (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .last    (last),
    .step_d  (step_d),
    .span_m1 (span_m1)
  );

  sdram_pwrup_drive u_drive (
    .clk       (clk),
    .rst       (rst),
    .step_d    (step_d),
    .mr_op     (mr_op),
    .emr_op    (emr_op),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .init_done (init_done)
  );

endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk #(
  parameter int TRP_CYCLES  = 3,
  parameter int TRFC_CYCLES = 9,
  parameter int TMRD_CYCLES = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [11:0] addr,
  input logic        init_done
);

  logic is_pre, is_ref, is_load, is_cmd;
  logic [2:0]  n_cmd;
  logic [15:0] since;

  assign is_pre  = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_ref  = !cs_n && !ras_n && !cas_n &&  we_n;
  assign is_load = !cs_n && !ras_n && !cas_n && !we_n;
  assign is_cmd  = !cs_n && !(ras_n && cas_n && we_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      n_cmd <= '0;
      since <= '0;
    end else if (is_cmd) begin
      if (n_cmd != 3'd7) n_cmd <= n_cmd + 3'd1;
      since <= 16'd1;
    end else if (since != 16'hFFFF) begin
      since <= since + 16'd1;
    end
  end

  a_r2_cke_high: assert property (@(posedge clk) disable iff (rst) cke);

  a_r4_precharge_all: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> (addr == 12'h400 && n_cmd == 3'd0));

  a_r5_order: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> (n_cmd == 3'd1 || n_cmd == 3'd2));

  a_r5_gap_trp: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && n_cmd == 3'd1) |-> (since == 16'(TRP_CYCLES)));

  a_r5_gap_trfc: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && (n_cmd == 3'd2 || n_cmd == 3'd3)) |-> (since == 16'(TRFC_CYCLES)));

  a_r5_gap_tmrd: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && n_cmd == 3'd4) |-> (since == 16'(TMRD_CYCLES)));

  a_r6_mode_word: assert property (@(posedge clk) disable iff (rst)
    (is_load && !addr[11]) |-> (n_cmd == 3'd3 && !addr[10] && addr[8:7] == 2'b00));

  a_r7_ext_word: assert property (@(posedge clk) disable iff (rst)
    (is_load && addr[11]) |-> (n_cmd == 3'd4 && addr[10:7] == 4'b0000));

  a_r8_done_timing: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (n_cmd == 3'd5 && since == 16'(TMRD_CYCLES)));

  a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    init_done |-> !is_cmd);

endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(
  .TRP_CYCLES  (TRP_CYCLES),
  .TRFC_CYCLES (TRFC_CYCLES),
  .TMRD_CYCLES (TMRD_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;

  localparam int S    = 30;
  localparam int TRP  = 3;
  localparam int TRFC = 7;
  localparam int TMRD = 2;

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam logic [3:0] C_LOAD = 4'b0000;

  typedef struct {
    int         cyc;
    logic [3:0] cmd;
    logic [11:0] addr;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] mr_op = '0;
  logic [10:0] emr_op = '0;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [11:0] addr;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail = 0;
  int   edges = 0;
  int   exp_done = -1;
  int   cke_bad = 0;
  logic done_prev = 1'b0;

  always #4 clk = ~clk;

  sdram_pwrup_seq #(
    .STARTUP_CYCLES (S),
    .TRP_CYCLES     (TRP),
    .TRFC_CYCLES    (TRFC),
    .TMRD_CYCLES    (TMRD)
  ) u_sdram_pwrup_seq (
    .clk (clk), .rst (rst), .mr_op (mr_op), .emr_op (emr_op),
    .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .addr (addr), .init_done (init_done)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mode_word(logic [10:0] op);
    return {1'b0, 1'b0, op[9], 2'b00, op[6:0]};
  endfunction

  function automatic logic [11:0] ext_word(logic [10:0] op);
    return {1'b1, 4'b0000, op[6:0]};
  endfunction

  // Driver side of the scoreboard: expected commands for one full run.
  task automatic push_sequence(logic [10:0] mo, logic [10:0] eo);
    int t;
    t = S - 1;
    q.push_back('{t, C_PRE, 12'h400, "R3/R4 precharge"});
    t += TRP;
    q.push_back('{t, C_REF, 12'h000, "R5 refresh 1"});
    t += TRFC;
    q.push_back('{t, C_REF, 12'h000, "R5 refresh 2"});
    t += TRFC;
    q.push_back('{t, C_LOAD, mode_word(mo), "R6 mode load"});
    t += TMRD;
    q.push_back('{t, C_LOAD, ext_word(eo), "R7 ext load"});
    exp_done = t + TMRD;
  endtask

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    logic [3:0] c;
    int k;
    c = {cs_n, ras_n, cas_n, we_n};
    if (!cke) cke_bad++;
    if (rst || edges == 0) begin
      done_prev = 1'b0;
    end else begin
      k = edges - 1;
      if (c != C_NOP) begin
        if (init_done) begin
          check(1'b0, "R9", "command after done", int'(c), int'(C_NOP));
        end else if (q.size() == 0) begin
          check(1'b0, "R5", "unexpected command", int'(c), int'(C_NOP));
        end else begin
          exp_t e;
          e = q.pop_front();
          check(k == e.cyc, e.tag, "cycle", k, e.cyc);
          check(c == e.cmd, e.tag, "pins", int'(c), int'(e.cmd));
          check(addr == e.addr, e.tag, "addr", int'(addr), int'(e.addr));
        end
      end
      if (init_done && !done_prev) check(k == exp_done, "R8", "done cycle", k, exp_done);
      if (!init_done && done_prev) check(1'b0, "R9", "done dropped", 0, 1);
      done_prev = init_done;
    end
  end

  task automatic check_reset_state(string req);
    check({cs_n, ras_n, cas_n, we_n} == C_NOP, req, "reset pins",
          int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
    check(addr == 12'h000, req, "reset addr", int'(addr), 0);
    check(init_done == 1'b0, req, "reset done", int'(init_done), 0);
    check(cke == 1'b1, req, "reset cke", int'(cke), 1);
  endtask

  task automatic finish_run(string req);
    repeat (exp_done + 12) @(posedge clk);
    @(negedge clk);
    check(q.size() == 0, req, "commands left", q.size(), 0);
    check(init_done == 1'b1, "R9", "done held", int'(init_done), 1);
    check({cs_n, ras_n, cas_n, we_n} == C_NOP, "R9", "idle after done",
          int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
  endtask

  initial begin
    // Run 1: typical opcodes.
    mr_op  = 11'h232;
    emr_op = 11'h021;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1");
    push_sequence(mr_op, emr_op);
    @(posedge clk); #1 rst = 1'b0;
    finish_run("R5");

    // Run 2: reset after done, all-ones opcodes, then reset mid-sequence.
    @(posedge clk); #1 rst = 1'b1;
    q.delete();
    mr_op  = 11'h7FF;
    emr_op = 11'h7FF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R10");
    push_sequence(mr_op, emr_op);
    @(posedge clk); #1 rst = 1'b0;
    repeat (S - 1 + TRP + 2) @(posedge clk);
    #1 rst = 1'b1;
    @(negedge clk);
    check(q.size() == 3, "R10", "commands before abort", q.size(), 3);
    q.delete();
    @(posedge clk);
    @(negedge clk);
    check_reset_state("R10");

    // Run 3: restart after the abort, with the reserved bits still all ones.
    push_sequence(mr_op, emr_op);
    @(posedge clk); #1 rst = 1'b0;
    finish_run("R10");

    // Run 4: mixed opcode bits.
    @(posedge clk); #1 rst = 1'b1;
    q.delete();
    mr_op  = 11'h5A5;
    emr_op = 11'h7C3;
    repeat (2) @(posedge clk);
    push_sequence(mr_op, emr_op);
    @(posedge clk); #1 rst = 1'b0;
    finish_run("R6");

    check(cke_bad == 0, "R2", "cycles with cke low", cke_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule